// File: doc/BRIEF.md
# Byte-Fed CRC-16 Accumulator with Control Register

This block keeps a running 16-bit cyclic redundancy check over a stream of bytes. Software talks to it through a small byte-wide register window. A control register sets the engine's behaviour. A data port takes one byte per write. Two result addresses give the upper and lower halves of the checksum. Each accepted byte is folded into the accumulator in the clock edge that accepts it. The update uses generator 0x1021, MSB first, with eight shift steps unrolled into one cycle.

A self-clearing command bit restarts the computation from an all-zeros or all-ones starting value. Two view bits change only how the result is read back: one mirrors its bit order, the other complements every bit. When both are set, the mirroring is done first and the complement second. The stored accumulator is never changed by these bits. A mode bit raises a request line toward a transfer agent. Each acknowledge from that agent delivers one byte on a side bus, which the engine folds in exactly like a register write.

Register window (reg_addr): 0 = control, 1 = data in, 2 = result upper byte, 3 = result lower byte. Control bits: 7 = clear command, 6:4 unused, 3 = transfer-request mode, 2 = mirror view, 1 = complement view, 0 = start-value select.

Top module: `crc16_engine`

## Requirements
- R1: After reset the control register reads 0x00, both result bytes read 0x00 and dma_req is low.
- R2: Control bits 7:4 always read as 0. Bits 3:0 read back the value last written to them.
- R3: Writing the control register with bit 7 set loads the accumulator with 0x0000 if bit 0 of that same write is 0, or with 0xFFFF if it is 1, at the edge of that write.
- R4: A write to address 1 folds the byte into the accumulator (polynomial 0x1021, MSB first, no reflection) at that edge. Starting from 0xFFFF, the bytes "123456789" give 0x29B1.
- R5: With control bit 2 set, result bit i reads as accumulator bit 15-i.
- R6: With control bit 1 set, the result reads as the bitwise complement of the accumulator.
- R7: With bits 2 and 1 both set, the result is the complement of the mirrored value. Clearing the view bits brings back the unchanged accumulator.
- R8: A byte presented on dma_data with dma_ack in the same cycle as a clear command is dropped, and the accumulator holds the start value.
- R9: dma_req follows control bit 3. While bit 3 is set, each cycle with dma_ack high folds dma_data in like an address-1 write. While bit 3 is clear, dma_ack has no effect.
- R10: The result bytes are stable in any cycle with no register write and no dma_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 data, 2 result high, 3 result low) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| dma_req | output | 1 | Byte request to transfer agent |
| dma_ack | input | 1 | Transfer agent delivers a byte this cycle |
| dma_data | input | 8 | Byte delivered with dma_ack |

## Verification
The bench builds the block with its default 16-bit checksum and 8-bit byte width. This keeps a single byte step small enough to sweep completely. All 256 byte values are run from both start values. For each one, all four combinations of the mirror and complement bits are read back and compared with a bit-serial model computed in the bench. The standard nine-character check string is run through both the register path and the request/acknowledge path. Directed cases cover a clear colliding with a delivered byte, and acknowledges arriving while request mode is off.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
   typedef enum logic [1:0] {
      REG_CTRL   = 2'd0,
      REG_DATA   = 2'd1,
      REG_RES_HI = 2'd2,
      REG_RES_LO = 2'd3
   } reg_sel_e;

   localparam int unsigned CB_CLEAR = 7;
   localparam int unsigned CB_DMA   = 3;
   localparam int unsigned CB_FLIP  = 2;
   localparam int unsigned CB_INV   = 1;
   localparam int unsigned CB_SEED  = 0;

   typedef struct packed {
      logic dma;
      logic flip;
      logic inv;
      logic seed;
   } ctrl_t;
endpackage

// File: rtl/crc_ctrl_reg.sv
module crc_ctrl_reg
   import crc16_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic [DATA_W-1:0] wdata,
   output ctrl_t             ctrl_q,
   output logic              clr_pulse,
   output logic              clr_seed,
   output logic [DATA_W-1:0] readback
);
   if (DATA_W <= CB_CLEAR) begin : g_bad_w
      $error("crc_ctrl_reg: DATA_W must exceed the clear bit position");
   end

   // Clear is a one-cycle command; it is never stored.
   assign clr_pulse = wr_ctrl & wdata[CB_CLEAR];
   assign clr_seed  = wdata[CB_SEED];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q.dma  <= wdata[CB_DMA];
         ctrl_q.flip <= wdata[CB_FLIP];
         ctrl_q.inv  <= wdata[CB_INV];
         ctrl_q.seed <= wdata[CB_SEED];
      end
   end

   always_comb begin
      readback          = '0;
      readback[CB_DMA]  = ctrl_q.dma;
      readback[CB_FLIP] = ctrl_q.flip;
      readback[CB_INV]  = ctrl_q.inv;
      readback[CB_SEED] = ctrl_q.seed;
   end
endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
   parameter int unsigned CRC_W  = 16,
   parameter int unsigned DATA_W = 8,
   parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [CRC_W-1:0]  crc_out
);
   if (CRC_W < 2 || DATA_W < 1) begin : g_bad_w
      $error("crc_byte_step: unsupported widths");
   end

   logic [CRC_W-1:0] stage [0:DATA_W];
   assign stage[0] = crc_in;

   // One shift/XOR step per input bit, MSB of the byte first.
   for (genvar g = 0; g < DATA_W; g++) begin : g_step
      logic fb;
      assign fb = stage[g][CRC_W-1] ^ data_in[DATA_W-1-g];
      assign stage[g+1] = {stage[g][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   assign crc_out = stage[DATA_W];
endmodule

// File: rtl/crc_result_view.sv
module crc_result_view #(
   parameter int unsigned CRC_W = 16
) (
   input  logic [CRC_W-1:0] raw,
   input  logic             flip,
   input  logic             inv,
   output logic [CRC_W-1:0] view
);
   logic [CRC_W-1:0] mirrored;
   logic [CRC_W-1:0] ordered;

   for (genvar i = 0; i < CRC_W; i++) begin : g_mirror
      assign mirrored[i] = raw[CRC_W-1-i];
   end

   // Mirror first, complement second.
   assign ordered = flip ? mirrored : raw;
   assign view    = ordered ^ {CRC_W{inv}};
endmodule

// File: rtl/crc16_engine.sv
module crc16_engine
   import crc16_pkg::*;
#(
   parameter int unsigned CRC_W  = 16,
   parameter int unsigned DATA_W = 8,
   parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              dma_req,
   input  logic              dma_ack,
   input  logic [DATA_W-1:0] dma_data
);
   localparam logic [CRC_W-1:0] SEED_ZERO = '0;
   localparam logic [CRC_W-1:0] SEED_ONES = '1;

   if (CRC_W != 2 * DATA_W) begin : g_bad_split
      $error("crc16_engine: result must split into exactly two bytes");
   end

   ctrl_t             ctrl_q;
   logic              clr_pulse;
   logic              clr_seed;
   logic [DATA_W-1:0] ctrl_rb;
   logic              wr_ctrl;
   logic              wr_data;
   logic              take_dma;
   logic              take_byte;
   logic [DATA_W-1:0] byte_in;
   logic [CRC_W-1:0]  acc_q;
   logic [CRC_W-1:0]  acc_next;
   logic [CRC_W-1:0]  view;

   assign wr_ctrl  = reg_wr && (reg_addr == REG_CTRL);
   assign wr_data  = reg_wr && (reg_addr == REG_DATA);
   assign take_dma = dma_ack && ctrl_q.dma;
   assign take_byte = wr_data || take_dma;
   assign byte_in  = wr_data ? reg_wdata : dma_data;
   assign dma_req  = ctrl_q.dma;

   crc_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (wr_ctrl),
      .wdata     (reg_wdata),
      .ctrl_q    (ctrl_q),
      .clr_pulse (clr_pulse),
      .clr_seed  (clr_seed),
      .readback  (ctrl_rb)
   );

   crc_byte_step #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY)) u_step (
      .crc_in  (acc_q),
      .data_in (byte_in),
      .crc_out (acc_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clr_pulse) begin
         acc_q <= clr_seed ? SEED_ONES : SEED_ZERO;
      end else if (take_byte) begin
         acc_q <= acc_next;
      end
   end

   crc_result_view #(.CRC_W(CRC_W)) u_view (
      .raw  (acc_q),
      .flip (ctrl_q.flip),
      .inv  (ctrl_q.inv),
      .view (view)
   );

   always_comb begin
      unique case (reg_sel_e'(reg_addr))
         REG_CTRL:   reg_rdata = ctrl_rb;
         REG_RES_HI: reg_rdata = view[CRC_W-1 -: DATA_W];
         REG_RES_LO: reg_rdata = view[DATA_W-1:0];
         default:    reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/crc16_engine_chk.sv
module crc16_engine_chk #(
   parameter int unsigned CRC_W  = 16,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [1:0]        reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              dma_req,
   input logic              dma_ack,
   input logic [CRC_W-1:0]  acc
);
   logic clr_cmd;
   assign clr_cmd = reg_wr && (reg_addr == 2'd0) && reg_wdata[7];

   a_r2_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 2'd0) |-> (reg_rdata[7:4] == 4'h0));

   a_r3_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
      clr_cmd |=> (acc == ($past(reg_wdata[0]) ? {CRC_W{1'b1}} : {CRC_W{1'b0}})));

   a_r8_clear_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_cmd && dma_ack) |=> (acc == {CRC_W{$past(reg_wdata[0])}}));

   a_r9_req_follows_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd0) |=> (dma_req == $past(reg_wdata[3])));

   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && !dma_ack) |=> $stable(acc));
endmodule

bind crc16_engine crc16_engine_chk #(.CRC_W(CRC_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .dma_req   (dma_req),
   .dma_ack   (dma_ack),
   .acc       (acc_q)
);

// File: tb/tb_crc16_engine.sv
module tb_crc16_engine;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       dma_req;
   logic       dma_ack = 1'b0;
   logic [7:0] dma_data = 8'h00;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   crc16_engine dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req),
      .dma_ack(dma_ack), .dma_data(dma_data)
   );

   function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r = c ^ {d, 8'h00};
      for (int k = 0; k < 8; k++)
         r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
      return r;
   endfunction

   function automatic logic [15:0] ref_view(input logic [15:0] c, input logic fl, input logic iv);
      logic [15:0] m;
      for (int k = 0; k < 16; k++) m[k] = fl ? c[15-k] : c[k];
      return iv ? ~m : m;
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic rd_res(output logic [15:0] r);
      logic [7:0] h, l;
      rd(2'd2, h);
      rd(2'd3, l);
      r = {h, l};
   endtask

   task automatic ack(input logic [7:0] d);
      @(negedge clk);
      dma_ack = 1'b1; dma_data = d;
      @(negedge clk);
      dma_ack = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [7:0]  b;
      logic [15:0] r, exp;
      string       msg;
      msg = "123456789";

      repeat (3) @(negedge clk);
      // R1: reset state
      rd(2'd0, b);  check("R1 ctrl", {8'h00, b}, 16'h0000);
      rd_res(r);    check("R1 result", r, 16'h0000);
      check("R1 dma_req", {15'd0, dma_req}, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: clear bit and unused bits read zero, low bits read back
      wr(2'd0, 8'hF5);
      rd(2'd0, b);  check("R2 readback", {8'h00, b}, 16'h0005);
      rd_res(r);    check("R5 flip of ones", r, 16'hFFFF);

      // R3/R4/R5/R6/R7: all bytes, both seeds, all view modes
      for (int s = 0; s < 2; s++) begin
         for (int v = 0; v < 256; v++) begin
            wr(2'd0, 8'h80 | 8'(s));
            rd_res(r); check(s ? "R3 seed ones" : "R3 seed zero", r, s ? 16'hFFFF : 16'h0000);
            wr(2'd1, 8'(v));
            exp = ref_step(s ? 16'hFFFF : 16'h0000, 8'(v));
            for (int m = 0; m < 4; m++) begin
               wr(2'd0, 8'(m << 1) | 8'(s));
               rd_res(r);
               check(m == 0 ? "R4 byte update" : m == 1 ? "R6 invert" :
                     m == 2 ? "R5 flip" : "R7 flip+invert",
                     r, ref_view(exp, m[1], m[0]));
            end
         end
      end

      // R4: check string via register path
      wr(2'd0, 8'h81);
      for (int i = 0; i < 9; i++) wr(2'd1, msg[i]);
      rd_res(r); check("R4 check string", r, 16'h29B1);
      wr(2'd0, 8'h07);
      rd_res(r); check("R7 both on string", r, ref_view(16'h29B1, 1'b1, 1'b1));
      wr(2'd0, 8'h01);
      rd_res(r); check("R7 accumulator unchanged", r, 16'h29B1);

      // R10: idle cycles keep result
      repeat (5) @(negedge clk);
      rd_res(r); check("R10 idle hold", r, 16'h29B1);

      // R9: ack ignored while mode off
      ack(8'h55);
      rd_res(r); check("R9 ack ignored", r, 16'h29B1);
      check("R9 req low", {15'd0, dma_req}, 16'h0000);

      // R9: request path
      wr(2'd0, 8'h89);
      check("R9 req high", {15'd0, dma_req}, 16'h0001);
      for (int i = 0; i < 9; i++) ack(msg[i]);
      rd_res(r); check("R9 string via ack", r, 16'h29B1);

      // R8: clear and ack in the same cycle
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h88;
      dma_ack = 1'b1; dma_data = 8'hA5;
      @(negedge clk);
      reg_wr = 1'b0; dma_ack = 1'b0;
      rd_res(r); check("R8 byte dropped on clear", r, 16'h0000);

      wr(2'd0, 8'h00);
      check("R9 req cleared", {15'd0, dma_req}, 16'h0000);
      ack(8'h31);
      rd_res(r); check("R9 ack ignored after clear", r, 16'h0000);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule